// File: doc/BRIEF.md
# Transmit FCS Append Controller

This block sits in the byte-wide transmit path of a 10 Mb/s Ethernet MAC, between the transmit FIFO and the serializer that adds the preamble. Frame bytes, from the destination address through the last data byte, come in on a valid/ready stream with a last-byte flag. Each accepted byte goes out unchanged in the same cycle while a CRC-32 frame check sequence is built over it. Preamble, sync and collision handling are done elsewhere.

Two control pins set what happens after the last byte: `fcs_off` suppresses the check sequence and `pad_en` asks for short-frame padding. Both pins are sampled only in the cycle in which the last byte of a frame is accepted. That sample decides the frame's tail. With padding the block sends zero bytes until the frame reaches the minimum length and then the four FCS bytes. Without padding it either sends the four FCS bytes or ends the frame on the data byte.

Back-pressure rules: during the data phase `in_ready` equals `out_ready`, and each input handshake is also an output handshake. During the pad and FCS phases the block is the source: `in_ready` is 0, and `out_valid` stays high with `out_data` and `out_last` held until `out_ready` accepts the byte. A synchronous `sw_rst` pulse drops any partly seen frame.

Top module: `fcs_append_ctl`

## Requirements
- R1: While in the data phase, an accepted input byte appears on `out_data` in the same cycle, unchanged, and `in_ready` follows `out_ready`.
- R2: `fcs_off` and `pad_en` are used only as sampled with the accepted byte that has `in_last`=1; their values on earlier bytes of the frame have no effect.
- R3: If the sampled `fcs_off`=1 and `pad_en`=0, the frame ends on its last data byte (`out_last`=1 on that byte) with nothing appended.
- R4: If the sampled `pad_en`=1, the FCS is appended whatever `fcs_off` is.
- R5: The FCS uses polynomial 0x04C11DB7, is preset to all ones, takes each byte bit 7 first, and is complemented. It is sent as 4 bytes, bits 31:24 first, and `out_last`=1 on the fourth byte.
- R6: With the sampled `pad_en`=1 and fewer than MIN_BYTES (default 60: 14 header bytes plus 46 payload bytes) input bytes, zero bytes are inserted to bring the frame to MIN_BYTES before the FCS. The zero bytes are included in the CRC. Frames of MIN_BYTES or more get no padding.
- R7: With the sampled `pad_en`=0, short frames are not padded.
- R8: During the pad and FCS phases `in_ready`=0, and a byte not taken by `out_ready` is held with `out_valid`=1 and stable `out_data` and `out_last`.
- R9: After `rst_n` or a `sw_rst` pulse, the block is in the data phase with no output pending and the CRC preset. A frame after a `sw_rst` that hit mid-frame gets an FCS over its own bytes only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous reset pulse; drops the frame in progress |
| fcs_off | input | 1 | Suppress the FCS; sampled with the last byte |
| pad_en | input | 1 | Pad short frames and force the FCS; sampled with the last byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Marks the final byte of the frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Output byte: data, pad or FCS |
| out_last | output | 1 | Marks the final output byte of the frame |

## Verification
The hardest case to reach from the ports is proving that the control pins count only on the last byte. The bench drives the opposite values of `fcs_off` and `pad_en` on every non-final byte of every frame and the intended values only on the final one. A wrong sample point then changes the frame length or the FCS. Stalls from `out_ready` are placed inside the pad and FCS phases. A `sw_rst` pulse is given in the middle of a frame, and the check is that the FCS of the next frame covers only that frame's bytes.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_PRESET = '1;

  typedef enum logic [1:0] {PH_DATA = 2'd0, PH_PAD = 2'd1, PH_FCS = 2'd2} phase_t;

  // One byte through the CRC shift register, bit 7 first.
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                input logic [7:0] b);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      fb = r[CRC_W-1] ^ b[k];
      r = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/fcs_crc_reg.sv
module fcs_crc_reg
  import fcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic [7:0]       din,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= CRC_PRESET;
    else if (clear) crc <= CRC_PRESET;
    else if (en)    crc <= crc_byte(crc, din);
  end
endmodule

// File: rtl/fcs_len_count.sv
module fcs_len_count #(
  parameter int MIN_BYTES = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic short_after
);
  localparam int CW = $clog2(MIN_BYTES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_BYTES);

  logic [CW-1:0] cnt_q;

  // High when the byte being counted now still leaves the frame short.
  assign short_after = (int'(cnt_q) + 1) < MIN_BYTES;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clear)                cnt_q <= '0;
    else if (inc && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fcs_append_ctl.sv
module fcs_append_ctl
  import fcs_pkg::*;
#(
  parameter int MIN_BYTES = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_rst,
  input  logic       fcs_off,
  input  logic       pad_en,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last
);
  localparam int FCS_BYTES = CRC_W / 8;
  localparam int IW = $clog2(FCS_BYTES);
  localparam logic [IW-1:0] IDX_END = IW'(FCS_BYTES - 1);

  phase_t          phase;
  logic [IW-1:0]   fcs_idx;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] fcs_shift;
  logic            crc_en, crc_clr, short_after;
  logic [7:0]      crc_din;
  logic            want_fcs, hs_in, hs_out, tail_done;

  assign want_fcs  = !fcs_off || pad_en;
  assign hs_in     = in_valid && in_ready;
  assign hs_out    = out_valid && out_ready;
  assign fcs_shift = (~crc_q) << (8 * fcs_idx);
  assign tail_done = (phase == PH_FCS) && hs_out && (fcs_idx == IDX_END);

  always_comb begin
    out_valid = 1'b0;
    out_data  = 8'h00;
    out_last  = 1'b0;
    in_ready  = 1'b0;
    crc_en    = 1'b0;
    crc_din   = 8'h00;
    unique case (phase)
      PH_DATA: begin
        out_valid = in_valid;
        out_data  = in_data;
        out_last  = in_last && !want_fcs;
        in_ready  = out_ready;
        crc_en    = hs_in;
        crc_din   = in_data;
      end
      PH_PAD: begin
        out_valid = 1'b1;
        crc_en    = hs_out;
      end
      PH_FCS: begin
        out_valid = 1'b1;
        out_data  = fcs_shift[CRC_W-1 -: 8];
        out_last  = (fcs_idx == IDX_END);
      end
      default: ;
    endcase
  end

  assign crc_clr = sw_rst || tail_done ||
                   ((phase == PH_DATA) && hs_in && in_last && !want_fcs);

  fcs_crc_reg u_crc (
    .clk(clk), .rst_n(rst_n), .clear(crc_clr), .en(crc_en),
    .din(crc_din), .crc(crc_q)
  );

  fcs_len_count #(.MIN_BYTES(MIN_BYTES)) u_len (
    .clk(clk), .rst_n(rst_n), .clear(crc_clr), .inc(crc_en),
    .short_after(short_after)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_DATA;
      fcs_idx <= '0;
    end else if (sw_rst) begin
      phase   <= PH_DATA;
      fcs_idx <= '0;
    end else begin
      unique case (phase)
        PH_DATA:
          if (hs_in && in_last && want_fcs)
            phase <= (pad_en && short_after) ? PH_PAD : PH_FCS;
        PH_PAD:
          if (hs_out && !short_after) phase <= PH_FCS;
        PH_FCS:
          if (hs_out) begin
            fcs_idx <= fcs_idx + 1'b1;
            if (fcs_idx == IDX_END) phase <= PH_DATA;
          end
        default: phase <= PH_DATA;
      endcase
    end
  end
endmodule

// File: rtl/fcs_append_chk.sv
module fcs_append_chk
  import fcs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sw_rst,
  input logic       fcs_off,
  input logic       pad_en,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_last,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input phase_t     phase
);
  // R1: accepted input byte leaves unchanged in the same cycle
  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (out_valid && out_ready && out_data == in_data));

  // R3: suppressed FCS ends the frame on the data byte
  p_nofcs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && in_valid && in_ready && in_last && fcs_off && !pad_en)
      |-> out_last);

  // R5: after the final output byte the block is back in the data phase
  p_end_r5: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (out_valid && out_ready && out_last) |=> (phase == PH_DATA));

  // R6: pad bytes are zero and never the last byte
  p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAD) |-> (out_valid && out_data == 8'h00 && !out_last && !in_ready));

  // R8: a stalled appended byte is held
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (phase != PH_DATA && out_valid && !out_ready)
      |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R9: sw_rst returns to the data phase
  p_swrst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (phase == PH_DATA));
endmodule

bind fcs_append_ctl fcs_append_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .fcs_off(fcs_off), .pad_en(pad_en),
  .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .phase(phase)
);

// File: tb/fcs_append_ctl_test.sv
`timescale 1ns/1ps
module fcs_append_ctl_test;
  localparam int MIN = 60;
  localparam logic [31:0] POLY = 32'h04C11DB7;

  logic clk = 1'b0, rst_n = 1'b0, sw_rst = 1'b0;
  logic fcs_off = 1'b0, pad_en = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;

  int checks = 0, fails = 0;
  logic [7:0] dat[128];
  logic [7:0] exq[128];

  always #2.5 clk = ~clk;

  fcs_append_ctl #(.MIN_BYTES(MIN)) uut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .fcs_off(fcs_off), .pad_en(pad_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  // {length, fcs_off, pad_en, stall, seed}
  localparam logic [21:0] VEC [9] = '{
    {11'd64, 1'b0, 1'b0, 1'b0, 8'h11},  // R5 plain FCS
    {11'd64, 1'b1, 1'b0, 1'b0, 8'h22},  // R3 suppressed
    {11'd64, 1'b1, 1'b1, 1'b1, 8'h33},  // R4 override, long
    {11'd20, 1'b0, 1'b1, 1'b0, 8'h44},  // R6 pad
    {11'd20, 1'b1, 1'b1, 1'b1, 8'h55},  // R4 R6 pad overrides off
    {11'd20, 1'b0, 1'b0, 1'b1, 8'h66},  // R7 no pad
    {11'd59, 1'b1, 1'b1, 1'b0, 8'h77},  // R6 one pad byte
    {11'd60, 1'b0, 1'b1, 1'b1, 8'h88},  // R6 exact minimum
    {11'd1,  1'b0, 1'b1, 1'b0, 8'h99}   // R6 single byte
  };

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int k = 7; k >= 0; k--) begin
      if (r[31] ^ b[k]) r = (r << 1) ^ POLY;
      else              r = r << 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // R2: non-final bytes carry the opposite control values
  task automatic run_frame(input int len, input bit nof, input bit pad,
                           input bit stall, input logic [7:0] seed, input string req);
    int n, sent, got, bad, lastpos, cyc;
    logic [31:0] c;
    bit done;
    c = 32'hFFFF_FFFF;
    n = 0;
    for (int i = 0; i < len; i++) begin
      dat[i] = seed + 8'(i * 37) ^ 8'(i >> 2);
      exq[n] = dat[i]; c = ref_crc(c, dat[i]); n++;
    end
    if (pad) while (n < MIN) begin exq[n] = 8'h00; c = ref_crc(c, 8'h00); n++; end
    if (!nof || pad) begin
      c = ~c;
      for (int k = 0; k < 4; k++) begin exq[n] = c[31-8*k -: 8]; n++; end
    end
    sent = 0; got = 0; bad = 0; lastpos = -1; cyc = 0; done = 0;
    while (!done && cyc < 3000) begin
      @(posedge clk); #1;
      in_valid  = (sent < len);
      in_data   = (sent < len) ? dat[sent] : 8'h00;
      in_last   = (sent == len - 1);
      fcs_off   = in_last ? nof : !nof;
      pad_en    = in_last ? pad : !pad;
      out_ready = stall ? ((cyc % 4) != 1) : 1'b1;
      @(negedge clk);
      if (in_valid && in_ready) sent++;
      if (out_valid && out_ready) begin
        if (got < 128 && out_data !== exq[got]) bad++;
        if (out_last) begin done = 1; lastpos = got; end
        got++;
      end
      cyc++;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
    chk(bad == 0, req, $sformatf("byte mismatches len=%0d", len), bad, 0);
    chk(got == n && lastpos == n - 1, req, "output length", got, n);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cnt;
    logic [7:0] held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready follows out_ready", in_ready, 1);

    foreach (VEC[v]) begin
      run_frame(int'(VEC[v][21:11]), VEC[v][10], VEC[v][9], VEC[v][8],
                VEC[v][7:0], "R2/R5/vec");
    end

    // R8 stall inside pad phase
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_data = 8'(i + 1); in_last = (i == 2);
      fcs_off = 1'b0; pad_en = 1'b1; out_ready = 1'b1;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    chk(out_valid && out_data == 8'h00 && !in_ready, "R8", "pad byte offered",
        int'(out_data), 0);
    held = out_data;
    repeat (3) @(negedge clk);
    chk(out_valid && out_data == held && !in_ready, "R8", "pad byte held",
        int'(out_data), int'(held));
    @(posedge clk); #1 out_ready = 1'b1;
    cnt = 0;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (out_valid && out_ready) begin
        cnt++;
        if (out_last) break;
      end
    end
    chk(cnt == MIN - 3 + 4, "R6", "pad plus FCS bytes after stall", cnt, MIN + 1);

    // R9 sw_rst mid-frame
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_data = 8'hA0 + 8'(i); in_last = 1'b0;
    end
    @(posedge clk); #1 in_valid = 1'b0; sw_rst = 1'b1;
    @(posedge clk); #1 sw_rst = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R9", "no output after sw_rst", out_valid, 0);
    run_frame(30, 1'b0, 1'b0, 1'b0, 8'h5C, "R9");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule